// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the byte-level protocol engine of a two-wire serial memory slave that fronts a 256-byte array. A separate bus front end filters the clock and data lines. It hands this engine one-cycle strobes for each clock rising and falling edge, and for each START and STOP condition, together with the sampled data level. The engine decodes the control byte and keeps one shared address pointer. It drives acknowledge bits and read data onto the line through an open-drain pull-down request.

Write transactions send each received data byte, with its target address, to an external page buffer. A STOP then asks an external write-cycle controller to program the array. Read transactions fetch bytes from a memory read port, which is assumed to return data in the same cycle as its address. While the write-cycle controller reports busy, the engine acknowledges nothing. A host can therefore poll for completion by sending control bytes until one is acknowledged.

Top module: `eeprom_slave_engine`

## Requirements
- R1: A control byte is accepted when its four most significant bits are 1010, whatever the value of bits 3..1. Bit 0 selects the direction, with 1 for read and 0 for write. Bits arrive MSB first and are sampled on the clock rising-edge strobe.
- R2: For each accepted byte, the engine asserts `sda_drive_low`. The pull-down starts at the falling-edge strobe that ends the eighth bit and is released at the falling-edge strobe that ends the ninth bit. This applies to the control byte, the word address and every data byte.
- R3: While `wc_busy` is high when a byte completes, that byte gets no acknowledge, the control byte included. The engine then ignores the bus until the next START.
- R4: In a write, the byte after the control byte loads the address pointer. Each later byte produces one `buf_we` pulse that carries the pointer value and the received data.
- R5: After each data byte in a write, only pointer bits [2:0] advance, wrapping inside the 8-byte page. Bits [7:3] stay unchanged.
- R6: A START that follows a write with no data bytes requests no write cycle. The pointer keeps the loaded word address, so a following read returns the data at that address.
- R7: A read sends the byte at the pointer first, as the current-address read. The pointer advances by one for every byte sent.
- R8: A master acknowledge (data line low on the ninth clock of a read byte) makes the engine send the next byte. The pointer wraps from 255 to 0.
- R9: A master no-acknowledge ends the read. `sda_drive_low` stays low-inactive until the next START, whatever clocks follow.
- R10: A control byte with a wrong device code gets no acknowledge. Later bytes are ignored until the next START.
- R11: A STOP returns the engine to idle. `wc_start` pulses for one cycle after a STOP only if at least one data byte was acknowledged since the last START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise | input | 1 | Strobe: serial clock rose |
| scl_fall | input | 1 | Strobe: serial clock fell |
| start_det | input | 1 | Strobe: START condition seen |
| stop_det | input | 1 | Strobe: STOP condition seen |
| sda_in | input | 1 | Sampled data line level |
| sda_drive_low | output | 1 | Request to pull the data line low |
| rd_addr | output | 8 | Memory read port address |
| rd_data | input | 8 | Memory read port data, same cycle |
| buf_we | output | 1 | Page buffer write strobe |
| buf_addr | output | 8 | Page buffer target address |
| buf_data | output | 8 | Page buffer data byte |
| wc_start | output | 1 | Request to start a write cycle |
| wc_busy | input | 1 | Write cycle in progress |

## Verification
The bench targets the following corner cases:

- **Don't-care select bits.** It sweeps all eight values of the ignored select bits. It also tries every wrong device code. A decoder that compared the full upper seven bits would refuse good control bytes. One that skipped the check would acknowledge strangers.
- **Page wrap.** A ten-byte page write starts at an address five bytes into a page. A pointer that carried into bit 3 would send data to the next page.
- **Random and sequential reads.** A random read is set up at 0xFE and streams across the top of memory. A full 256-byte sequential sweep follows. Together they expose a pointer that does not wrap, increments twice, or does not survive the repeated START.
- **Busy polling and write requests.** Polling during busy, a no-acknowledge followed by extra clocks, and an address-only write check three faults. These are acknowledging during a write cycle, driving after the master gives up, and requesting a write cycle without data.

// File: rtl/eeslv_pkg.sv
// Package: shared types and constants of the serial EEPROM slave engine.
// Assumes a byte-wide serial protocol with a 4-bit device code.
package eeslv_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_READ,
        ST_SKIP
    } eeslv_state_t;
endpackage

// File: rtl/eeslv_rx_shift.sv
// Bit counter and receive shifter. It counts clock rises in a 9-bit frame:
// 8 data bits, then 1 acknowledge bit. It samples the master acknowledge
// on the ninth rise.
// Assumes the front end gives mutually exclusive one-cycle strobes.
module eeslv_rx_shift #(
    parameter int BITS = 8,
    localparam int CNT_W = $clog2(BITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_in,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [BITS-1:0]  rx_byte,
    output logic             mack,
    output logic             byte_done,
    output logic             ack_done
);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BITS + 1);

    // Count bits, shift data bits in, capture the master acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_cnt <= '0;
            mack    <= 1'b0;
        end else if (scl_rise && bit_cnt < CNT_DATA) begin
            rx_byte <= {rx_byte[BITS-2:0], sda_in};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_rise && bit_cnt == CNT_DATA) begin
            mack    <= ~sda_in;
            bit_cnt <= CNT_ACK;
        end else if (scl_fall && bit_cnt == CNT_ACK) begin
            bit_cnt <= '0;
        end
    end

    assign byte_done = scl_fall && (bit_cnt == CNT_DATA);
    assign ack_done  = scl_fall && (bit_cnt == CNT_ACK);

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_ACK); // R2
endmodule

// File: rtl/eeslv_addr_ptr.sv
// Shared address pointer. A word address loads it. Write data advances it
// inside the page; reads advance it linearly with wrap at the top.
// Assumes that load, page step and linear step never coincide.
module eeslv_addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_lin,
    output logic [ADDR_W-1:0] ptr
);
    // Update the pointer: load, page-local step, or full-range step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc_page) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
        end else if (inc_lin) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page && !load |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R5
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_lin && !load && !inc_page && (&ptr) |=> ptr == '0); // R8
endmodule

// File: rtl/eeprom_slave_engine.sv
// Protocol engine of a two-wire serial EEPROM slave with 2**ADDR_W bytes.
// It decodes the control byte and drives acknowledge and read data. Write
// data goes to a page buffer port; a STOP requests the write cycle.
// Assumes: front-end strobes are one cycle wide and exclusive, and the
// memory read port is combinational (rd_data follows rd_addr in the same cycle).
module eeprom_slave_engine
    import eeslv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_data,
    output logic              wc_start,
    input  logic              wc_busy
);
    localparam int CNT_W = $clog2(BYTE_W + 2);

    eeslv_state_t      state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_q;
    logic              mack, byte_done, ack_done;
    logic              rw_q, got_data, drv_q;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_load, ptr_inc_page, ptr_inc_lin;

    eeslv_rx_shift #(.BITS(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_det | stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_in   (sda_in),
        .bit_cnt  (bit_cnt),
        .rx_byte  (rx_byte),
        .mack     (mack),
        .byte_done(byte_done),
        .ack_done (ack_done)
    );

    // Pointer control strobes, decoded from the state and frame events.
    always_comb begin
        ptr_load     = (state == ST_WADDR) && byte_done && !wc_busy && !start_det && !stop_det;
        ptr_inc_page = (state == ST_WDATA) && byte_done && !wc_busy && !start_det && !stop_det;
        ptr_inc_lin  = !start_det && !stop_det && ack_done &&
                       (((state == ST_CTRL) && rw_q) || ((state == ST_READ) && mack));
    end

    eeslv_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val(rx_byte[ADDR_W-1:0]),
        .inc_page(ptr_inc_page),
        .inc_lin (ptr_inc_lin),
        .ptr     (ptr)
    );

    assign rd_addr       = ptr;
    assign sda_drive_low = drv_q;

    // Transaction state machine and data-line pull-down control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            drv_q    <= 1'b0;
            rw_q     <= 1'b0;
            got_data <= 1'b0;
            tx_q     <= '0;
        end else if (start_det) begin
            state    <= ST_CTRL;
            drv_q    <= 1'b0;
            got_data <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            drv_q    <= 1'b0;
            got_data <= 1'b0;
        end else begin
            case (state)
                ST_CTRL: begin
                    if (byte_done) begin
                        if (rx_byte[BYTE_W-1:BYTE_W-4] == DEV_CODE && !wc_busy) begin
                            drv_q <= 1'b1;
                            rw_q  <= rx_byte[0];
                        end else begin
                            state <= ST_SKIP;
                        end
                    end else if (ack_done) begin
                        if (rw_q) begin
                            state <= ST_READ;
                            tx_q  <= rd_data;
                            drv_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            state <= ST_WADDR;
                            drv_q <= 1'b0;
                        end
                    end
                end
                ST_WADDR, ST_WDATA: begin
                    if (byte_done) begin
                        if (!wc_busy) begin
                            drv_q <= 1'b1;
                            if (state == ST_WDATA) got_data <= 1'b1;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end else if (ack_done) begin
                        drv_q <= 1'b0;
                        state <= ST_WDATA;
                    end
                end
                ST_READ: begin
                    if (byte_done) begin
                        drv_q <= 1'b0;
                    end else if (ack_done) begin
                        if (mack) begin
                            tx_q  <= rd_data;
                            drv_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            state <= ST_SKIP;
                            drv_q <= 1'b0;
                        end
                    end else if (scl_fall && bit_cnt != '0) begin
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        drv_q <= ~tx_q[BYTE_W-2];
                    end
                end
                default: drv_q <= 1'b0;
            endcase
        end
    end

    // Page buffer port and write-cycle request, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
            wc_start <= 1'b0;
        end else begin
            buf_we   <= ptr_inc_page;
            wc_start <= stop_det && got_data;
            if (ptr_inc_page) begin
                buf_addr <= ptr;
                buf_data <= rx_byte;
            end
        end
    end

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && wc_busy && state != ST_READ |=> !sda_drive_low); // R3
    AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_CTRL && !sda_drive_low); // R1
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE && !sda_drive_low); // R11
    AST_WC_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wc_start |-> $past(stop_det)); // R11
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |-> !sda_drive_low); // R9
    AST_BUF_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> !buf_we); // R4
endmodule

// File: tb/eeprom_slave_engine_bench.sv
// Bench: drives front-end strobes as a bus master would and models the
// memory read port arithmetically. It checks the slave responses.
module eeprom_slave_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_rise = 1'b0, scl_fall = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic sda_in = 1'b1;
    logic sda_drive_low;
    logic [7:0] rd_addr, rd_data, buf_addr, buf_data;
    logic buf_we, wc_start;
    logic wc_busy = 1'b0;

    int errors = 0, checks = 0;
    int wc_cnt = 0, log_n = 0;
    logic [7:0] log_addr [16];
    logic [7:0] log_data [16];
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [7:0] a);
        return 8'(a * 8'd29 + 8'd17);
    endfunction
    assign rd_data = memf(rd_addr);

    eeprom_slave_engine u_eeprom_slave_engine (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_in(sda_in),
        .sda_drive_low(sda_drive_low), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .wc_start(wc_start), .wc_busy(wc_busy)
    );

    always @(negedge clk) begin
        if (wc_start) wc_cnt++;
        if (buf_we && log_n < 16) begin
            log_addr[log_n] = buf_addr;
            log_data[log_n] = buf_data;
            log_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        sda_in = 1'b1;
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One clock period: drive data, rise, sample slave drive in high phase, fall.
    task automatic bit_cycle(input logic b, output logic s);
        sda_in = b;
        @(negedge clk) scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
        @(negedge clk);
        s = sda_drive_low;
        scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
        bit_cycle(1'b1, ack);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            v[i] = ~s;
        end
        bit_cycle(~master_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic s;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset drive", int'(sda_drive_low), 0);
        chk("R11 reset wc_start", int'(wc_start), 0);

        // R1/R2: all don't-care select values accepted.
        for (int dc = 0; dc < 8; dc++) begin
            pulse_start();
            send_byte({4'b1010, 3'(dc), 1'b0}, ack);
            chk("R1 R2 ack control", int'(ack), 1);
            pulse_stop();
        end

        // R10: wrong device codes refused and the rest ignored.
        for (int code = 0; code < 16; code++) begin
            if (code == 10) continue;
            pulse_start();
            send_byte({4'(code), 4'b0000}, ack);
            chk("R10 no ack bad code", int'(ack), 0);
            send_byte(8'hA0, ack);
            chk("R10 ignored until START", int'(ack), 0);
            pulse_stop();
        end

        // R4/R5: ten data bytes from 0x35 wrap within the page 0x30..0x37.
        pulse_start();
        send_byte(8'hA0, ack);
        send_byte(8'h35, ack);
        chk("R2 ack word address", int'(ack), 1);
        for (int i = 0; i < 10; i++) begin
            send_byte(8'(8'h40 + i), ack);
            chk("R2 ack data", int'(ack), 1);
        end
        pulse_stop();
        chk("R11 commit after data", wc_cnt, 1);
        chk("R4 buffer writes", log_n, 10);
        for (int i = 0; i < 10; i++) begin
            chk("R5 page address", int'(log_addr[i]), 8'h30 + ((5 + i) % 8));
            chk("R4 buffer data", int'(log_data[i]), 8'h40 + i);
        end

        // R3: busy refuses control bytes of both directions; polling then succeeds.
        wc_busy = 1'b1;
        pulse_start();
        send_byte(8'hA0, ack);
        chk("R3 no ack busy write", int'(ack), 0);
        pulse_start();
        send_byte(8'hA1, ack);
        chk("R3 no ack busy read", int'(ack), 0);
        pulse_stop();
        wc_busy = 1'b0;
        pulse_start();
        send_byte(8'hA0, ack);
        chk("R3 ack after busy", int'(ack), 1);
        pulse_stop();
        chk("R11 no commit without data", wc_cnt, 1);

        // R7/R9: current-address read at 0x37 (pointer after page write), then NACK.
        pulse_start();
        send_byte(8'hA1, ack);
        chk("R7 ack read", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R7 current address", int'(v), int'(memf(8'h37)));
        for (int i = 0; i < 9; i++) begin
            bit_cycle(1'b1, s);
            chk("R9 released after NACK", int'(s), 0);
        end
        pulse_stop();
        pulse_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R7 pointer advanced", int'(v), int'(memf(8'h38)));
        pulse_stop();

        // R6/R8: random read at 0xFE streams across the top.
        pulse_start();
        send_byte(8'hA2, ack);
        send_byte(8'hFE, ack);
        pulse_start();
        send_byte(8'hA1, ack);
        chk("R6 ack after restart", int'(ack), 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, v);
            chk("R8 sequential wrap", int'(v), int'(memf(8'(8'hFE + i))));
        end
        pulse_stop();
        chk("R6 no commit on restart", wc_cnt, 1);

        // R11: address-only write gives no request; one data byte gives one.
        pulse_start();
        send_byte(8'hA0, ack);
        send_byte(8'h10, ack);
        pulse_stop();
        chk("R11 address only", wc_cnt, 1);
        base = log_n;
        pulse_start();
        send_byte(8'hA0, ack);
        send_byte(8'h10, ack);
        send_byte(8'h5A, ack);
        pulse_stop();
        chk("R11 one data byte", wc_cnt, 2);
        chk("R4 single byte address", int'(log_addr[base]), 8'h10);

        // R7/R8: full sequential sweep from 0, then current read returns 0 again.
        pulse_start();
        send_byte(8'hA0, ack);
        send_byte(8'h00, ack);
        pulse_start();
        send_byte(8'hA1, ack);
        for (int a = 0; a < 256; a++) begin
            recv_byte(a != 255, v);
            chk("R8 sweep", int'(v), int'(memf(8'(a))));
        end
        pulse_stop();
        pulse_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R8 pointer wrapped", int'(v), int'(memf(8'h00)));
        pulse_stop();

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule